// File: doc/BRIEF.md
# PWM Dead-Band Generator with Shadowed Delays

This block sits between a PWM action stage and the output pins of a power stage. It takes two raw PWM waveforms, A and B, and inserts a programmable number of clock cycles of delay on rising edges, on falling edges, or on both. The two delay values are 14-bit counts. A short write port sets them, together with a control word. The control word holds per-delay shadow enables, load-event selectors, an output routing mode and two polarity-invert bits.

Each delay value can be written straight into its active copy, or staged in a shadow copy. A staged value is moved into the active copy when the time-base counter reports zero, period, or either of them. A delay already in progress always finishes with the value it started with. The routing mode can also chain both delays on the A path. That either drives output A or builds output B as a phase-shifted copy of A.

Top module: `dbgen_top`

## Requirements
- R1: While reset is held and just after its release, both outputs are low, both active delays are 0, the control word is all zeros (no shadowing, route 0, no inversion), and every delay path treats its input as having been low for a long time.
- R2: A rising-edge delay of D holds its output low until the input has been sampled high at D+1 consecutive clock edges. The output then goes high at that edge and falls at the first edge that samples the input low. A high pulse of D samples or fewer produces no output pulse.
- R3: A falling-edge delay of D is the mirror of R2. Its output goes low only after the input has been sampled low at D+1 consecutive edges, and it rises at the first edge that samples the input high. A low gap of D samples or fewer leaves the output high.
- R4: A delay of 0 passes the input through a single register stage.
- R5: A delay path takes its delay value from the active register in the cycle where it samples the starting edge. A later change to the active value does not alter a delay already running.
- R6: With shadowing off for a delay (control bit 0 for the rising delay, bit 1 for the falling delay), a write to its address loads the active value at the same clock edge as the write.
- R7: With shadowing on, a write to a delay address changes only the shadow copy. The active value stays unchanged until a selected load event occurs.
- R8: The load selector (control bits 3:2 for the rising delay, 5:4 for the falling delay) means: 0 load on the zero strobe, 1 load on the period strobe, 2 load on either, 3 never load. A load copies the shadow value held before that edge.
- R9: When a load and the matching input edge fall in the same cycle, that edge is delayed by the value that was active before the load. The next edge uses the loaded value.
- R10: Routing (control bits 7:6): 0 gives A = rising-delayed A and B = falling-delayed B. 1 gives A = falling-delayed A and B = rising-delayed B. 2 gives A = A with both delays chained (two register stages when both delays are 0) and B = B through one register. 3 gives A = A through one register and B = A with both delays chained.
- R11: In route 3 with both delays equal to S, B repeats each A high pulse longer than S samples, shifted by S cycles plus the chain latency. An A pulse of S samples or fewer leaves B low.
- R12: Control bit 8 inverts output A and bit 9 inverts output B. Each invert is applied after the delay and routing, and takes effect in the cycle after the control write.
- R13: Address 0 is the control word (bits 9:0), address 1 the rising delay and address 2 the falling delay (data bits 13:0). Data bits above those fields are ignored, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W (16) | Register write data |
| ev_zero | input | 1 | Time-base counter equals zero strobe |
| ev_prd | input | 1 | Time-base counter equals period strobe |
| pwm_a_i | input | 1 | Raw PWM A |
| pwm_b_i | input | 1 | Raw PWM B |
| pwm_a_o | output | 1 | Conditioned PWM A |
| pwm_b_o | output | 1 | Conditioned PWM B |

## Verification
The bench targets pulses one sample shorter than, equal to and longer than the programmed delay. A path with an off-by-one counter would emit a sliver pulse or clip a good one. It rewrites the active delay in the middle of a running count and raises a load strobe in the same cycle as an input edge. A design that reads the delay on every cycle instead of latching it at the edge would shorten or stretch that edge. It steps every load-selector code with the wrong strobe and then the right one, so a decoder that mixes up zero and period, or that loads with code 3, moves the output edges at the wrong time. Phase-shift runs with A pulses shorter than the shift catch a chain that lets a delayed rise escape after A has already fallen.

// File: rtl/dbgen_pkg.sv
`timescale 1ns/1ps
package dbgen_pkg;
   localparam int REG_AW = 2;
   localparam int CTRL_W = 10;
   localparam int NUM_DLY = 2;

   localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
   localparam logic [REG_AW-1:0] ADDR_RED  = 2'd1;
   localparam logic [REG_AW-1:0] ADDR_FED  = 2'd2;

   typedef enum logic [1:0] {
      LD_ZERO = 2'd0,
      LD_PRD  = 2'd1,
      LD_BOTH = 2'd2,
      LD_NONE = 2'd3
   } load_e;

   typedef enum logic [1:0] {
      RT_SPLIT   = 2'd0,
      RT_SWAP    = 2'd1,
      RT_STACK_A = 2'd2,
      RT_PHASE_B = 2'd3
   } route_e;

   typedef struct packed {
      logic   inv_b;
      logic   inv_a;
      route_e route;
      load_e  fed_mode;
      load_e  red_mode;
      logic   fed_sh;
      logic   red_sh;
   } ctrl_t;
endpackage

// File: rtl/dbgen_regs.sv
`timescale 1ns/1ps
module dbgen_regs
   import dbgen_pkg::*;
#(
   parameter int CNT_W  = 14,
   parameter int DATA_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [REG_AW-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          ev_zero,
   input  logic                          ev_prd,
   output ctrl_t                         ctrl_o,
   output logic [NUM_DLY-1:0][CNT_W-1:0] act_o,
   output logic [NUM_DLY-1:0][CNT_W-1:0] shd_o
);
   logic [CTRL_W-1:0] ctrl_raw;
   logic              unused_wr_bits;

   assign unused_wr_bits = ^wr_data;
   assign ctrl_o         = ctrl_t'(ctrl_raw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_raw <= '0;
      end else if (wr_en && wr_addr == ADDR_CTRL) begin
         ctrl_raw <= wr_data[CTRL_W-1:0];
      end
   end

   // one channel per delay: 0 = rising, 1 = falling
   for (genvar c = 0; c < NUM_DLY; c++) begin : g_ch
      localparam logic [REG_AW-1:0] MY_ADDR = (c == 0) ? ADDR_RED : ADDR_FED;

      logic             hit;
      logic             sh_en;
      logic             load;
      logic [1:0]       mode;
      logic [CNT_W-1:0] act_q;
      logic [CNT_W-1:0] shd_q;

      assign hit   = wr_en && (wr_addr == MY_ADDR);
      assign sh_en = ctrl_raw[c];
      assign mode  = ctrl_raw[2 + 2*c +: 2];

      always_comb begin
         case (load_e'(mode))
            LD_ZERO: load = ev_zero;
            LD_PRD:  load = ev_prd;
            LD_BOTH: load = ev_zero | ev_prd;
            default: load = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q <= '0;
            shd_q <= '0;
         end else begin
            if (hit) begin
               shd_q <= wr_data[CNT_W-1:0];
            end
            if (!sh_en) begin
               if (hit) begin
                  act_q <= wr_data[CNT_W-1:0];
               end
            end else if (load) begin
               act_q <= shd_q;
            end
         end
      end

      assign act_o[c] = act_q;
      assign shd_o[c] = shd_q;
   end
endmodule

// File: rtl/dbgen_delay.sv
`timescale 1ns/1ps
module dbgen_delay #(
   parameter int CNT_W   = 14,
   parameter bit FALLING = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [CNT_W-1:0] dly,
   output logic             dout
);
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic             IDLE_LVL = FALLING;

   logic             x_int;
   logic             prv_q;
   logic             y_q;
   logic             rise;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] held_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] eff_d;
   logic [CNT_W-1:0] inc;

   // a falling delay is a rising delay on the complemented waveform
   if (FALLING) begin : g_fall
      assign x_int = ~din;
      assign dout  = ~y_q;
   end else begin : g_rise
      assign x_int = din;
      assign dout  = y_q;
   end

   always_comb begin
      rise  = x_int & ~prv_q;
      inc   = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
      cnt_d = rise ? '0 : inc;
      eff_d = rise ? dly : held_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_q  <= IDLE_LVL;
         y_q    <= IDLE_LVL;
         cnt_q  <= '0;
         held_q <= '0;
      end else begin
         prv_q <= x_int;
         y_q   <= x_int && (cnt_d >= eff_d);
         if (x_int) begin
            cnt_q <= cnt_d;
         end
         if (rise) begin
            held_q <= dly;
         end
      end
   end
endmodule

// File: rtl/dbgen_route.sv
`timescale 1ns/1ps
module dbgen_route
   import dbgen_pkg::*;
(
   input  ctrl_t ctrl,
   input  logic  red_a,
   input  logic  fed_a,
   input  logic  fed_b,
   input  logic  red_b,
   input  logic  chain,
   input  logic  pass_a,
   input  logic  pass_b,
   output logic  pwm_a_o,
   output logic  pwm_b_o
);
   logic ya;
   logic yb;

   always_comb begin
      case (ctrl.route)
         RT_SPLIT: begin
            ya = red_a;
            yb = fed_b;
         end
         RT_SWAP: begin
            ya = fed_a;
            yb = red_b;
         end
         RT_STACK_A: begin
            ya = chain;
            yb = pass_b;
         end
         default: begin
            ya = pass_a;
            yb = chain;
         end
      endcase
      pwm_a_o = ya ^ ctrl.inv_a;
      pwm_b_o = yb ^ ctrl.inv_b;
   end
endmodule

// File: rtl/dbgen_top.sv
`timescale 1ns/1ps
module dbgen_top
   import dbgen_pkg::*;
#(
   parameter int CNT_W  = 14,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ev_zero,
   input  logic              ev_prd,
   input  logic              pwm_a_i,
   input  logic              pwm_b_i,
   output logic              pwm_a_o,
   output logic              pwm_b_o
);
   if (CNT_W < 2 || DATA_W < CNT_W || DATA_W < CTRL_W) begin : g_bad_cfg
      $error("dbgen_top: CNT_W must be >= 2 and DATA_W must cover CNT_W and the control word");
   end

   ctrl_t                         ctrl_q;
   logic [NUM_DLY-1:0][CNT_W-1:0] act_q;
   logic [NUM_DLY-1:0][CNT_W-1:0] shd_q;
   logic                          red_a;
   logic                          fed_a;
   logic                          fed_b;
   logic                          red_b;
   logic                          chain;
   logic                          pass_a_q;
   logic                          pass_b_q;

   dbgen_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ev_zero (ev_zero),
      .ev_prd  (ev_prd),
      .ctrl_o  (ctrl_q),
      .act_o   (act_q),
      .shd_o   (shd_q)
   );

   dbgen_delay #(.CNT_W(CNT_W), .FALLING(1'b0)) u_red_a (
      .clk(clk), .rst_n(rst_n), .din(pwm_a_i), .dly(act_q[0]), .dout(red_a));
   dbgen_delay #(.CNT_W(CNT_W), .FALLING(1'b1)) u_fed_a (
      .clk(clk), .rst_n(rst_n), .din(pwm_a_i), .dly(act_q[1]), .dout(fed_a));
   dbgen_delay #(.CNT_W(CNT_W), .FALLING(1'b1)) u_fed_b (
      .clk(clk), .rst_n(rst_n), .din(pwm_b_i), .dly(act_q[1]), .dout(fed_b));
   dbgen_delay #(.CNT_W(CNT_W), .FALLING(1'b0)) u_red_b (
      .clk(clk), .rst_n(rst_n), .din(pwm_b_i), .dly(act_q[0]), .dout(red_b));
   // chained path: falling delay applied to the rising-delayed A
   dbgen_delay #(.CNT_W(CNT_W), .FALLING(1'b1)) u_chain (
      .clk(clk), .rst_n(rst_n), .din(red_a), .dly(act_q[1]), .dout(chain));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_a_q <= 1'b0;
         pass_b_q <= 1'b0;
      end else begin
         pass_a_q <= pwm_a_i;
         pass_b_q <= pwm_b_i;
      end
   end

   dbgen_route u_route (
      .ctrl    (ctrl_q),
      .red_a   (red_a),
      .fed_a   (fed_a),
      .fed_b   (fed_b),
      .red_b   (red_b),
      .chain   (chain),
      .pass_a  (pass_a_q),
      .pass_b  (pass_b_q),
      .pwm_a_o (pwm_a_o),
      .pwm_b_o (pwm_b_o)
   );
endmodule

// File: rtl/dbgen_chk.sv
`timescale 1ns/1ps
module dbgen_chk
   import dbgen_pkg::*;
#(
   parameter int CNT_W  = 14,
   parameter int DATA_W = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [REG_AW-1:0]             wr_addr,
   input logic [DATA_W-1:0]             wr_data,
   input logic                          ev_zero,
   input logic                          ev_prd,
   input logic                          pwm_a_i,
   input logic                          pwm_b_i,
   input logic                          pwm_a_o,
   input logic                          pwm_b_o,
   input ctrl_t                         ctrl_q,
   input logic [NUM_DLY-1:0][CNT_W-1:0] act_q,
   input logic [NUM_DLY-1:0][CNT_W-1:0] shd_q
);
   // R6
   red_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_RED && !ctrl_q.red_sh) |=> act_q[0] == $past(wr_data[CNT_W-1:0]));

   // R7
   fed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.fed_sh && !ev_zero && !ev_prd) |=> $stable(act_q[1]));

   // R8
   red_zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.red_sh && ctrl_q.red_mode == LD_ZERO && ev_zero) |=> act_q[0] == $past(shd_q[0]));

   // R8
   red_never_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.red_sh && ctrl_q.red_mode == LD_NONE) |=> $stable(act_q[0]));

   // R2
   rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.route == RT_SPLIT && !ctrl_q.inv_a && !wr_en) |=> (!pwm_a_o || $past(pwm_a_i)));

   // R3
   fall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.route == RT_SPLIT && !ctrl_q.inv_b && !wr_en) |=> (pwm_b_o || !$past(pwm_b_i)));

   // R10
   phase_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.route == RT_PHASE_B && !ctrl_q.inv_a && !wr_en) |=> pwm_a_o == $past(pwm_a_i));
endmodule

bind dbgen_top dbgen_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .ev_zero (ev_zero),
   .ev_prd  (ev_prd),
   .pwm_a_i (pwm_a_i),
   .pwm_b_i (pwm_b_i),
   .pwm_a_o (pwm_a_o),
   .pwm_b_o (pwm_b_o),
   .ctrl_q  (ctrl_q),
   .act_q   (act_q),
   .shd_q   (shd_q)
);

// File: tb/sim_dbgen_top.sv
`timescale 1ns/1ps
module sim_dbgen_top;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic          ev_zero = 1'b0;
   logic          ev_prd = 1'b0;
   logic          a_i = 1'b0;
   logic          b_i = 1'b0;
   logic          a_o;
   logic          b_o;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    started = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   dbgen_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ev_zero(ev_zero), .ev_prd(ev_prd), .pwm_a_i(a_i), .pwm_b_i(b_i),
      .pwm_a_o(a_o), .pwm_b_o(b_o));

   // ---------------- behavioural reference ----------------
   // paths: 0 rise-A, 1 fall-A, 2 fall-B, 3 rise-B, 4 fall on rise-A
   int       m_run[5];
   int       m_held[5];
   bit       m_prv[5];
   bit       m_hi[5];
   bit       m_pa = 1'b0;
   bit       m_pb = 1'b0;
   int       m_act[2];
   int       m_shd[2];
   bit [9:0] m_ctrl = '0;

   function automatic bit is_fall(int i);
      return (i == 1 || i == 2 || i == 4);
   endfunction

   function automatic bit m_out(int i);
      return is_fall(i) ? ~m_hi[i] : m_hi[i];
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 5; i++) begin
         m_run[i]  = 0;
         m_held[i] = 0;
         m_prv[i]  = is_fall(i);
         m_hi[i]   = is_fall(i);
      end
      for (int c = 0; c < 2; c++) begin
         m_act[c] = 0;
         m_shd[c] = 0;
      end
      m_ctrl = '0;
      m_pa = 1'b0;
      m_pb = 1'b0;
   endtask

   // a pulse counts its samples; the delay is fixed when the pulse starts
   task automatic m_path(int i, bit xin, int d);
      bit x;
      x = is_fall(i) ? ~xin : xin;
      if (x) begin
         if (!m_prv[i]) begin
            m_held[i] = d;
            m_run[i]  = 0;
         end else begin
            m_run[i] = m_run[i] + 1;
         end
         m_hi[i] = (m_run[i] >= m_held[i]);
      end else begin
         m_hi[i] = 1'b0;
      end
      m_prv[i] = x;
   endtask

   task automatic m_regs();
      bit [9:0] old_ctrl;
      old_ctrl = m_ctrl;
      for (int c = 0; c < 2; c++) begin
         bit       hit;
         bit       ev;
         bit [1:0] md;
         hit = wr_en && (int'(wr_addr) == c + 1);
         md  = old_ctrl[2 + 2*c +: 2];
         ev  = (md == 2'd0) ? ev_zero :
               (md == 2'd1) ? ev_prd :
               (md == 2'd2) ? (ev_zero | ev_prd) : 1'b0;
         if (!old_ctrl[c]) begin
            if (hit) begin
               m_act[c] = int'(wr_data[13:0]);
               m_shd[c] = int'(wr_data[13:0]);
            end
         end else begin
            if (ev) m_act[c] = m_shd[c];
            if (hit) m_shd[c] = int'(wr_data[13:0]);
         end
      end
      if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data[9:0];
   endtask

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reset();
      end else begin
         bit chain_in;
         chain_in = m_out(0);
         m_path(0, a_i, m_act[0]);
         m_path(1, a_i, m_act[1]);
         m_path(2, b_i, m_act[1]);
         m_path(3, b_i, m_act[0]);
         m_path(4, chain_in, m_act[1]);
         m_pa = a_i;
         m_pb = b_i;
         m_regs();
      end
      started = 1'b1;
   end

   function automatic bit exp_a();
      bit y;
      case (m_ctrl[7:6])
         2'd0:    y = m_out(0);
         2'd1:    y = m_out(1);
         2'd2:    y = m_out(4);
         default: y = m_pa;
      endcase
      return y ^ m_ctrl[8];
   endfunction

   function automatic bit exp_b();
      bit y;
      case (m_ctrl[7:6])
         2'd0:    y = m_out(2);
         2'd1:    y = m_out(3);
         2'd2:    y = m_pb;
         default: y = m_out(4);
      endcase
      return y ^ m_ctrl[9];
   endfunction

   // compare away from the active edge
   always @(negedge clk) begin
      if (started) begin
         n_chk = n_chk + 2;
         if (a_o !== exp_a()) begin
            n_fail++;
            $display("FAIL %s out A at %0t: actual=%b expected=%b", cur_req, $time, a_o, exp_a());
         end
         if (b_o !== exp_b()) begin
            n_fail++;
            $display("FAIL %s out B at %0t: actual=%b expected=%b", cur_req, $time, b_o, exp_b());
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] ad, logic [DW-1:0] d);
      wr_en = 1'b1;
      wr_addr = ad;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_a(int w, int g);
      a_i = 1'b1;
      cyc(w);
      a_i = 1'b0;
      cyc(g);
   endtask

   task automatic gap_b(int w, int g);
      b_i = 1'b0;
      cyc(w);
      b_i = 1'b1;
      cyc(g);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      cur_req = "R1";
      cyc(3);
      rst_n = 1'b1;
      cyc(3);

      cur_req = "R4";
      b_i = 1'b1;
      pulse_a(1, 2);
      pulse_a(3, 3);
      for (int k = 0; k < 20; k++) begin
         b_i = k[1] ^ k[0];
         cyc(1);
      end
      b_i = 1'b1;
      cyc(3);

      cur_req = "R13";
      wr(2'd0, 16'hFC00);
      wr(2'd1, 16'hC005);
      wr(2'd2, 16'h8003);
      wr(2'd3, 16'hFFFF);
      cyc(2);

      cur_req = "R2";
      pulse_a(2, 8);
      pulse_a(5, 8);
      pulse_a(6, 8);
      pulse_a(10, 8);

      cur_req = "R3";
      gap_b(1, 8);
      gap_b(3, 8);
      gap_b(4, 8);
      gap_b(7, 8);

      cur_req = "R5";
      wr(2'd1, 16'd8);
      a_i = 1'b1;
      cyc(3);
      wr(2'd1, 16'd2);
      cyc(12);
      a_i = 1'b0;
      cyc(5);
      pulse_a(4, 6);

      cur_req = "R6";
      wr(2'd1, 16'd1);
      pulse_a(1, 4);
      pulse_a(2, 4);

      for (int m = 0; m < 4; m++) begin
         cur_req = "R7";
         wr(2'd0, DW'(16'h0003 | (m << 2) | (m << 4)));
         wr(2'd1, DW'(9 - m));
         wr(2'd2, DW'(6 - m));
         pulse_a(12, 10);
         gap_b(8, 10);
         cur_req = "R8";
         ev_prd = 1'b1;
         cyc(1);
         ev_prd = 1'b0;
         pulse_a(12, 10);
         gap_b(8, 10);
         ev_zero = 1'b1;
         cyc(1);
         ev_zero = 1'b0;
         pulse_a(12, 10);
         gap_b(8, 10);
         wr(2'd0, 16'h0000);
         wr(2'd1, 16'd3);
         wr(2'd2, 16'd2);
      end

      cur_req = "R9";
      wr(2'd0, 16'h0003);
      wr(2'd1, 16'd2);
      a_i = 1'b1;
      ev_zero = 1'b1;
      cyc(1);
      ev_zero = 1'b0;
      cyc(11);
      a_i = 1'b0;
      cyc(8);
      pulse_a(12, 8);
      wr(2'd0, 16'h0000);

      cur_req = "R10";
      for (int r = 0; r < 4; r++) begin
         wr(2'd0, DW'(r << 6));
         wr(2'd1, DW'(r + 1));
         wr(2'd2, DW'(3 - r));
         for (int k = 0; k < 60; k++) begin
            if ($urandom_range(0, 3) == 0) a_i = ~a_i;
            if ($urandom_range(0, 3) == 0) b_i = ~b_i;
            cyc(1);
         end
      end

      cur_req = "R11";
      wr(2'd0, 16'h00C0);
      wr(2'd1, 16'd4);
      wr(2'd2, 16'd4);
      a_i = 1'b0;
      cyc(6);
      pulse_a(10, 12);
      pulse_a(3, 12);
      pulse_a(4, 12);
      pulse_a(5, 12);
      pulse_a(9, 3);
      pulse_a(8, 12);

      cur_req = "R12";
      for (int v = 0; v < 4; v++) begin
         wr(2'd0, DW'(v << 8));
         for (int k = 0; k < 20; k++) begin
            if ($urandom_range(0, 2) == 0) a_i = ~a_i;
            if ($urandom_range(0, 2) == 0) b_i = ~b_i;
            cyc(1);
         end
      end

      cur_req = "R10";
      for (int k = 0; k < 3000; k++) begin
         if ($urandom_range(0, 4) == 0) a_i = ~a_i;
         if ($urandom_range(0, 4) == 0) b_i = ~b_i;
         ev_zero = ($urandom_range(0, 15) == 0);
         ev_prd  = ($urandom_range(0, 15) == 0);
         if ($urandom_range(0, 40) == 0) begin
            logic [1:0] ad;
            ad = 2'($urandom_range(0, 3));
            wr_en = 1'b1;
            wr_addr = ad;
            wr_data = (ad == 2'd0) ? DW'($urandom_range(0, 1023)) : DW'($urandom_range(0, 12));
         end else begin
            wr_en = 1'b0;
         end
         cyc(1);
      end
      wr_en = 1'b0;
      ev_zero = 1'b0;
      ev_prd = 1'b0;
      cyc(4);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      finish_run();
   end
endmodule